// File: doc/BRIEF.md
# Cache Line Error Retirement Controller

This block sits between a small set-associative cache data array and its requesters. It holds the array itself. The array stores one SEC-DED codeword per line, together with a dirty flag. Each read is checked against the code. A clean word is returned as it is. A word with one flipped bit is corrected before it leaves the block, and the repaired codeword is then written back into the same slot one cycle later. A word with two flipped bits cannot be repaired.

Each line keeps a saturating count of the corrections it has needed. When that count reaches a programmable threshold, the line is withdrawn from service. An uncorrectable word also withdraws the line at once. The recovery path depends on the line's dirty flag:

- A clean line that failed is reloaded from memory, and the waiting read completes with the memory data.
- A dirty line is handed to a salvage port instead. The port carries a poison mark when the data could not be corrected. When the data was only corrected and the line reached its threshold, the port carries the good data with no poison mark.

The map of withdrawn lines is exported. It can be preloaded during reset, so a line stays out of service across a restart. A victim-choice port names the lowest usable way of a set, or reports that the whole set is withdrawn. Reads of a withdrawn line go straight to memory as uncached accesses.

Top module: `line_retire_ctl`

## Requirements
- R1: An accepted read (`rd_req` and `rd_ready` high at a rising edge) produces `rsp_valid` high for exactly one cycle. For a line that is not withdrawn and has no uncorrectable error, it is registered on the next rising edge after the accepting one.
- R2: Codeword layout: bit 0 is the overall parity of all other bits. Bits 1..CW-1 are Hamming positions, with check bits at the powers of two. Data bits fill the remaining positions in ascending order, data bit 0 first. Each check bit makes the XOR of all positions that have its index bit set equal to zero. A word with exactly one flipped bit returns the original data with `rsp_fixed` high.
- R3: After a corrected read, the repaired codeword is stored back into the array, so the next read of that line returns `rsp_fixed` low. A clean read causes no write-back.
- R4: In the cycle the correction write-back is performed (the cycle `rsp_valid` of the correcting read is high), `rd_ready` is low for a request to the same set and high for any other set.
- R5: Each line counts its corrections. When the incremented count reaches `thresh`, the line is withdrawn. Its bit in `ret_map` rises at the same edge as the response, and no write-back occurs. The count saturates at its maximum, and a threshold of 0 acts as 1.
- R6: An uncorrectable word in a clean line withdraws the line and pulses `mem_req` with `mem_bypass` low and the line's set and way. `rd_ready` stays low until `mem_rsp_valid`. The response then carries `mem_rsp_data` with `rsp_poison` low.
- R7: An uncorrectable word in a dirty line withdraws the line. It returns the response with `rsp_poison` high and pulses `slv_valid` with `slv_poison` high and the line's set and way, all at the same edge, and it issues no memory request.
- R8: A dirty line withdrawn by the threshold pulses `slv_valid` with `slv_poison` low, and `slv_data` holds the corrected data.
- R9: A read of a withdrawn line pulses `mem_req` with `mem_bypass` high and returns `mem_rsp_data`.
- R10: `alloc_way` is the lowest-numbered way of `alloc_set` whose line is not withdrawn. `alloc_none` is high when every way of the set is withdrawn.
- R11: `ret_map` bit set*WAYS+way marks a withdrawn line. It is loaded from `ret_init` while `rst` is high, and its bits are never cleared afterwards.
- R12: After reset, `rsp_valid`, `mem_req` and `slv_valid` are low and `rd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thresh | input | CNT_W | Correction count that withdraws a line |
| ret_init | input | LINES | Withdrawn-line map loaded during reset |
| ret_map | output | LINES | Current withdrawn-line map |
| wr_en | input | 1 | Store a codeword into the array |
| wr_set | input | SET_W | Set of the store |
| wr_way | input | WAY_W | Way of the store |
| wr_code | input | CW | Codeword to store |
| wr_dirty | input | 1 | Dirty flag stored with the codeword |
| rd_req | input | 1 | Read request |
| rd_set | input | SET_W | Set of the read |
| rd_way | input | WAY_W | Way of the read |
| rd_ready | output | 1 | Read can be accepted this cycle |
| rsp_valid | output | 1 | Read response pulse |
| rsp_data | output | DATA_W | Read data |
| rsp_fixed | output | 1 | Response needed a single-bit correction |
| rsp_poison | output | 1 | Response data is uncorrectable |
| mem_req | output | 1 | Memory fetch pulse |
| mem_bypass | output | 1 | Fetch is an uncached access of a withdrawn line |
| mem_set | output | SET_W | Set of the fetch |
| mem_way | output | WAY_W | Way of the fetch |
| mem_rsp_valid | input | 1 | Memory data valid |
| mem_rsp_data | input | DATA_W | Memory data |
| slv_valid | output | 1 | Dirty-line salvage pulse |
| slv_poison | output | 1 | Salvaged data is poisoned |
| slv_set | output | SET_W | Set of the salvaged line |
| slv_way | output | WAY_W | Way of the salvaged line |
| slv_data | output | DATA_W | Salvaged data |
| alloc_set | input | SET_W | Set queried for a victim |
| alloc_way | output | WAY_W | Lowest usable way of that set |
| alloc_none | output | 1 | Every way of that set is withdrawn |

## Verification
The correction write-back and the acceptance of a new read can fall in the same cycle, because the repair is written during the cycle the response is presented. The bench provokes this overlap right after each corrected read. In the response cycle it probes `rd_ready` with the read set pointed first at the same set and then at a neighbouring one. It judges the result by the blocked versus open ready. It then re-reads the line and expects a clean word. The threshold case is the opposite check: when the line is withdrawn instead of repaired, the same probe must find the set open.

// File: rtl/lr_pkg.sv
package lr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_WAIT  = 2'd2
  } lr_state_e;

  typedef enum logic [1:0] {
    EK_CLEAN = 2'd0,
    EK_FIXED = 2'd1,
    EK_FATAL = 2'd2
  } lr_ecc_e;

  // smallest number of Hamming check bits covering dw data bits
  function automatic int lr_par_bits(input int dw);
    int p;
    p = 1;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

endpackage

// File: rtl/lr_secded_check.sv
module lr_secded_check
  import lr_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int PW = lr_par_bits(DATA_W),
  localparam int CW = DATA_W + PW + 1
) (
  input  logic [CW-1:0]     code,
  output lr_ecc_e           kind,
  output logic [DATA_W-1:0] data,
  output logic [CW-1:0]     fix_code
);

  logic [PW-1:0] syn;
  logic          par;

  // syndrome is the XOR of the positions of all set bits
  always_comb begin
    syn = '0;
    par = 1'b0;
    for (int j = 0; j < CW; j++) begin
      par = par ^ code[j];
      if (j > 0 && code[j]) syn = syn ^ PW'(j);
    end
  end

  always_comb begin
    fix_code = code;
    if (!par) begin
      kind = (syn == '0) ? EK_CLEAN : EK_FATAL;
    end else if (int'(syn) < CW) begin
      kind = EK_FIXED;
      fix_code[syn] = ~code[syn];
    end else begin
      kind = EK_FATAL;
    end
  end

  always_comb begin
    int k;
    k = 0;
    data = '0;
    for (int j = 1; j < CW; j++) begin
      if ((j & (j - 1)) != 0) begin
        data[k] = fix_code[j];
        k++;
      end
    end
  end

endmodule

// File: rtl/lr_line_health.sv
module lr_line_health #(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int CNT_W = 4,
  localparam int LINES = SETS * WAYS,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] thresh,
  input  logic [LINES-1:0] ret_init,
  input  logic             ev_fix,
  input  logic             ev_fatal,
  input  logic [IDX_W-1:0] ev_idx,
  output logic             over,
  output logic [LINES-1:0] ret_map,
  input  logic [SET_W-1:0] alloc_set,
  output logic [WAY_W-1:0] alloc_way,
  output logic             alloc_none
);

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (c == '1) ? c : c + 1'b1;
  endfunction

  logic [LINES-1:0][CNT_W-1:0] cnt_v;
  logic                        ev_retire;

  assign over      = sat_inc(cnt_v[ev_idx]) >= thresh;
  assign ev_retire = ev_fatal | (ev_fix & over);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [CNT_W-1:0] c;
    logic             r;
    logic             hit;
    assign hit = (ev_idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (rst) begin
        c <= '0;
        r <= ret_init[i];
      end else if (hit && ev_retire) begin
        c <= '0;
        r <= 1'b1;
      end else if (hit && ev_fix) begin
        c <= sat_inc(c);
      end
    end
    assign cnt_v[i]   = c;
    assign ret_map[i] = r;
  end

  // victim choice: lowest way whose line is still in service
  always_comb begin
    alloc_way  = '0;
    alloc_none = 1'b1;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!ret_map[IDX_W'(int'(alloc_set) * WAYS + w)]) begin
        alloc_way  = WAY_W'(w);
        alloc_none = 1'b0;
      end
    end
  end

  assert_alloc_skip_R10: assert property (@(posedge clk) disable iff (rst)
    !alloc_none |-> !ret_map[IDX_W'(int'(alloc_set) * WAYS + int'(alloc_way))]);

  assert_ret_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (ret_map & $past(ret_map)) == $past(ret_map));

endmodule

// File: rtl/line_retire_ctl.sv
module line_retire_ctl
  import lr_pkg::*;
#(
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4,
  localparam int LINES = SETS * WAYS,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int CW    = DATA_W + lr_par_bits(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  thresh,
  input  logic [LINES-1:0]  ret_init,
  output logic [LINES-1:0]  ret_map,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [CW-1:0]     wr_code,
  input  logic              wr_dirty,
  input  logic              rd_req,
  input  logic [SET_W-1:0]  rd_set,
  input  logic [WAY_W-1:0]  rd_way,
  output logic              rd_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_fixed,
  output logic              rsp_poison,
  output logic              mem_req,
  output logic              mem_bypass,
  output logic [SET_W-1:0]  mem_set,
  output logic [WAY_W-1:0]  mem_way,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              slv_valid,
  output logic              slv_poison,
  output logic [SET_W-1:0]  slv_set,
  output logic [WAY_W-1:0]  slv_way,
  output logic [DATA_W-1:0] slv_data,
  input  logic [SET_W-1:0]  alloc_set,
  output logic [WAY_W-1:0]  alloc_way,
  output logic              alloc_none
);

  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;

  function automatic logic [IDX_W-1:0] line_of(input logic [SET_W-1:0] s,
                                               input logic [WAY_W-1:0] w);
    return IDX_W'(int'(s) * WAYS + int'(w));
  endfunction

  // storage
  logic [CW-1:0]    arr [LINES];
  logic [LINES-1:0] dirty;

  // read pipeline state
  lr_state_e        st;
  logic [CW-1:0]    q_code;
  logic [SET_W-1:0] q_set;
  logic [WAY_W-1:0] q_way;
  logic             q_dirty;
  logic             q_ret;
  logic [IDX_W-1:0] q_idx;

  // pending correction write-back
  logic             wb_pend;
  logic [IDX_W-1:0] wb_idx;
  logic [SET_W-1:0] wb_set;
  logic [CW-1:0]    wb_code;

  // named internal events
  lr_ecc_e           kind;
  logic [DATA_W-1:0] dec_data;
  logic [CW-1:0]     fix_code;
  logic              rd_fire;
  logic              ev_fix;
  logic              ev_fatal;
  logic              over;

  assign q_idx    = line_of(q_set, q_way);
  assign rd_ready = (st == ST_IDLE) && !(wb_pend && rd_set == wb_set);
  assign rd_fire  = rd_req && rd_ready;
  assign ev_fix   = (st == ST_CHECK) && !q_ret && (kind == EK_FIXED);
  assign ev_fatal = (st == ST_CHECK) && !q_ret && (kind == EK_FATAL);

  lr_secded_check #(.DATA_W(DATA_W)) u_chk (
    .code     (q_code),
    .kind     (kind),
    .data     (dec_data),
    .fix_code (fix_code)
  );

  lr_line_health #(.SETS(SETS), .WAYS(WAYS), .CNT_W(CNT_W)) u_health (
    .clk        (clk),
    .rst        (rst),
    .thresh     (thresh),
    .ret_init   (ret_init),
    .ev_fix     (ev_fix),
    .ev_fatal   (ev_fatal),
    .ev_idx     (q_idx),
    .over       (over),
    .ret_map    (ret_map),
    .alloc_set  (alloc_set),
    .alloc_way  (alloc_way),
    .alloc_none (alloc_none)
  );

  // array: an external store to the same slot wins over the write-back
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) arr[i] <= '0;
      dirty <= '0;
    end else begin
      if (wb_pend) arr[wb_idx] <= wb_code;
      if (wr_en) begin
        arr[line_of(wr_set, wr_way)]   <= wr_code;
        dirty[line_of(wr_set, wr_way)] <= wr_dirty;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      q_code     <= '0;
      q_set      <= '0;
      q_way      <= '0;
      q_dirty    <= 1'b0;
      q_ret      <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      rsp_fixed  <= 1'b0;
      rsp_poison <= 1'b0;
      mem_req    <= 1'b0;
      mem_bypass <= 1'b0;
      mem_set    <= '0;
      mem_way    <= '0;
      slv_valid  <= 1'b0;
      slv_poison <= 1'b0;
      slv_set    <= '0;
      slv_way    <= '0;
      slv_data   <= '0;
      wb_pend    <= 1'b0;
      wb_idx     <= '0;
      wb_set     <= '0;
      wb_code    <= '0;
    end else begin
      rsp_valid  <= 1'b0;
      rsp_fixed  <= 1'b0;
      rsp_poison <= 1'b0;
      mem_req    <= 1'b0;
      slv_valid  <= 1'b0;
      wb_pend    <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (rd_fire) begin
            q_code  <= arr[line_of(rd_set, rd_way)];
            q_dirty <= dirty[line_of(rd_set, rd_way)];
            q_ret   <= ret_map[line_of(rd_set, rd_way)];
            q_set   <= rd_set;
            q_way   <= rd_way;
            st      <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          st <= ST_IDLE;
          if (q_ret) begin
            mem_req    <= 1'b1;
            mem_bypass <= 1'b1;
            mem_set    <= q_set;
            mem_way    <= q_way;
            st         <= ST_WAIT;
          end else if (kind == EK_CLEAN) begin
            rsp_valid <= 1'b1;
            rsp_data  <= dec_data;
          end else if (kind == EK_FIXED) begin
            rsp_valid <= 1'b1;
            rsp_data  <= dec_data;
            rsp_fixed <= 1'b1;
            if (over) begin
              if (q_dirty) begin
                slv_valid  <= 1'b1;
                slv_poison <= 1'b0;
                slv_set    <= q_set;
                slv_way    <= q_way;
                slv_data   <= dec_data;
              end
            end else begin
              wb_pend <= 1'b1;
              wb_idx  <= q_idx;
              wb_set  <= q_set;
              wb_code <= fix_code;
            end
          end else if (q_dirty) begin
            rsp_valid  <= 1'b1;
            rsp_data   <= dec_data;
            rsp_poison <= 1'b1;
            slv_valid  <= 1'b1;
            slv_poison <= 1'b1;
            slv_set    <= q_set;
            slv_way    <= q_way;
            slv_data   <= dec_data;
          end else begin
            mem_req    <= 1'b1;
            mem_bypass <= 1'b0;
            mem_set    <= q_set;
            mem_way    <= q_way;
            st         <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            rsp_valid <= 1'b1;
            rsp_data  <= mem_rsp_data;
            st        <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_rsp_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_fix_onebit_R2: assert property (@(posedge clk) disable iff (rst)
    ev_fix |-> $countones(q_code ^ fix_code) == 1);

  assert_wb_after_fix_R3: assert property (@(posedge clk) disable iff (rst)
    wb_pend |-> $past(st == ST_CHECK && kind == EK_FIXED));

  assert_mem_wait_R6: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (st == ST_WAIT && !rsp_valid));

  assert_slv_retired_R7: assert property (@(posedge clk) disable iff (rst)
    slv_valid |-> ret_map[line_of(slv_set, slv_way)]);

endmodule

// File: tb/sim_line_retire_ctl.sv
`timescale 1ns/100ps
module sim_line_retire_ctl;

  localparam int SETS = 4;
  localparam int WAYS = 2;
  localparam int DW   = 16;
  localparam int P    = 5;
  localparam int CW   = DW + P + 1;
  localparam int NV   = 6;
  localparam logic [DW-1:0] VD [NV] = '{16'h0000, 16'hA5C3, 16'h1234, 16'hFFFF, 16'h8001, 16'h7E7E};
  localparam int VF [NV] = '{-1, 0, 3, 7, 21, 1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] thresh = 4'd15;
  logic [7:0] ret_init = 8'h80;
  logic [7:0] ret_map;
  logic wr_en = 1'b0, wr_dirty = 1'b0;
  logic [1:0] wr_set = '0;
  logic [0:0] wr_way = '0;
  logic [CW-1:0] wr_code = '0;
  logic rd_req = 1'b0, rd_ready;
  logic [1:0] rd_set = '0;
  logic [0:0] rd_way = '0;
  logic rsp_valid, rsp_fixed, rsp_poison;
  logic [DW-1:0] rsp_data;
  logic mem_req, mem_bypass;
  logic [1:0] mem_set;
  logic [0:0] mem_way;
  logic mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic slv_valid, slv_poison;
  logic [1:0] slv_set;
  logic [0:0] slv_way;
  logic [DW-1:0] slv_data;
  logic [1:0] alloc_set = '0;
  logic [0:0] alloc_way;
  logic alloc_none;

  int errs = 0;
  int checks = 0;

  // captured response-cycle values
  int c_valid, c_data, c_fixed, c_poison, c_slv, c_slvp, c_slvset, c_slvway, c_slvdata;
  int c_mreq, c_mbyp, c_mset, c_mway, c_rdy_same, c_rdy_other, c_next, c_wait_rdy;

  always #2 clk = ~clk;

  line_retire_ctl u0 (
    .clk(clk), .rst(rst), .thresh(thresh), .ret_init(ret_init), .ret_map(ret_map),
    .wr_en(wr_en), .wr_set(wr_set), .wr_way(wr_way), .wr_code(wr_code), .wr_dirty(wr_dirty),
    .rd_req(rd_req), .rd_set(rd_set), .rd_way(rd_way), .rd_ready(rd_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_fixed(rsp_fixed), .rsp_poison(rsp_poison),
    .mem_req(mem_req), .mem_bypass(mem_bypass), .mem_set(mem_set), .mem_way(mem_way),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .slv_valid(slv_valid), .slv_poison(slv_poison), .slv_set(slv_set), .slv_way(slv_way),
    .slv_data(slv_data), .alloc_set(alloc_set), .alloc_way(alloc_way), .alloc_none(alloc_none)
  );

  // encoder restated from R2: place data, then solve each check bit
  function automatic logic [CW-1:0] enc(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    int n;
    logic b;
    c = '0;
    n = 0;
    for (int pos = 1; pos < CW; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        c[pos] = d[n];
        n++;
      end
    end
    for (int k = 0; k < P; k++) begin
      b = 1'b0;
      for (int pos = 1; pos < CW; pos++)
        if (((pos >> k) & 1) == 1 && pos != (1 << k)) b = b ^ c[pos];
      c[1 << k] = b;
    end
    c[0] = ^c[CW-1:1];
    return c;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put_line(input int s, input int w, input logic [CW-1:0] code, input logic d);
    @(negedge clk);
    wr_en = 1'b1; wr_set = 2'(s); wr_way = 1'(w); wr_code = code; wr_dirty = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic capture(input int s);
    c_valid = int'(rsp_valid); c_data = int'(rsp_data); c_fixed = int'(rsp_fixed);
    c_poison = int'(rsp_poison); c_slv = int'(slv_valid); c_slvp = int'(slv_poison);
    c_slvset = int'(slv_set); c_slvway = int'(slv_way); c_slvdata = int'(slv_data);
    rd_set = 2'(s);
    #0.2 c_rdy_same = int'(rd_ready);
    rd_set = 2'((s + 1) % SETS);
    #0.2 c_rdy_other = int'(rd_ready);
  endtask

  // read answered from the array; response registered one edge after acceptance
  task automatic do_read(input int s, input int w);
    @(negedge clk);
    rd_req = 1'b1; rd_set = 2'(s); rd_way = 1'(w);
    @(posedge clk);
    @(negedge clk);
    rd_req = 1'b0;
    @(posedge clk);
    @(negedge clk);
    c_mreq = int'(mem_req);
    capture(s);
    @(negedge clk);
    c_next = int'(rsp_valid);
  endtask

  // read answered by memory after a two-cycle wait
  task automatic read_mem(input int s, input int w, input logic [DW-1:0] md);
    @(negedge clk);
    rd_req = 1'b1; rd_set = 2'(s); rd_way = 1'(w);
    @(posedge clk);
    @(negedge clk);
    rd_req = 1'b0;
    @(posedge clk);
    @(negedge clk);
    c_mreq = int'(mem_req); c_mbyp = int'(mem_bypass);
    c_mset = int'(mem_set); c_mway = int'(mem_way);
    c_wait_rdy = int'(rd_ready);
    repeat (2) begin
      @(negedge clk);
      c_wait_rdy = c_wait_rdy | int'(rd_ready) | int'(mem_req);
    end
    mem_rsp_valid = 1'b1; mem_rsp_data = md;
    @(posedge clk);
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    capture(s);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state, R11 preload
    chk("R12 rsp_valid after reset", int'(rsp_valid), 0);
    chk("R12 mem_req after reset", int'(mem_req), 0);
    chk("R12 slv_valid after reset", int'(slv_valid), 0);
    chk("R12 rd_ready after reset", int'(rd_ready), 1);
    chk("R11 ret_map preload", int'(ret_map), 8'h80);
    alloc_set = 2'd3;
    #0.2 chk("R10 alloc skips withdrawn way", int'(alloc_way), 0);
    chk("R10 alloc_none with usable way", int'(alloc_none), 0);

    // vector table: sets 0 and 1, threshold high
    for (int i = 0; i < NV; i++) begin
      logic [CW-1:0] cw;
      int s, w;
      s = (i % 4) / 2;
      w = (i % 4) % 2;
      cw = enc(VD[i]);
      if (VF[i] >= 0) cw[VF[i]] = ~cw[VF[i]];
      put_line(s, w, cw, 1'b0);
      do_read(s, w);
      chk("R1 response pulse", c_valid, 1);
      chk("R1 response one cycle only", c_next, 0);
      chk("R2 read data", c_data, int'(VD[i]));
      chk("R2 fixed flag", c_fixed, (VF[i] >= 0) ? 1 : 0);
      if (VF[i] >= 0) begin
        do_read(s, w);
        chk("R3 re-read after write-back is clean", c_fixed, 0);
        chk("R3 re-read data", c_data, int'(VD[i]));
        chk("R3 clean read leaves set open", c_rdy_same, 1);
      end
    end

    // R4 write-back collides with a new read of the same set
    begin
      logic [CW-1:0] cw;
      cw = enc(16'h5A5A);
      cw[10] = ~cw[10];
      put_line(1, 0, cw, 1'b0);
      do_read(1, 0);
      chk("R4 same set blocked during write-back", c_rdy_same, 0);
      chk("R4 other set open during write-back", c_rdy_other, 1);
      do_read(1, 0);
      chk("R4 line repaired after write-back", c_fixed, 0);
    end

    // R5 threshold retirement of a clean line
    thresh = 4'd2;
    begin
      logic [CW-1:0] cw;
      cw = enc(16'h0F0F);
      cw[5] = ~cw[5];
      put_line(2, 0, cw, 1'b0);
      do_read(2, 0);
      chk("R5 first correction keeps line", int'(ret_map[4]), 0);
      put_line(2, 0, cw, 1'b0);
      do_read(2, 0);
      chk("R5 threshold reached withdraws line", int'(ret_map[4]), 1);
      chk("R5 corrected data still returned", c_data, 16'h0F0F);
      chk("R5 no write-back on withdrawal", c_rdy_same, 1);
      chk("R5 clean line not salvaged", c_slv, 0);
    end

    // R8 threshold withdrawal of a dirty line
    thresh = 4'd1;
    begin
      logic [CW-1:0] cw;
      cw = enc(16'hC0DE);
      cw[14] = ~cw[14];
      put_line(2, 1, cw, 1'b1);
      do_read(2, 1);
      chk("R8 salvage pulse", c_slv, 1);
      chk("R8 salvage not poisoned", c_slvp, 0);
      chk("R8 salvage data corrected", c_slvdata, 16'hC0DE);
      chk("R8 salvage set/way", c_slvset * 2 + c_slvway, 5);
      chk("R8 line withdrawn", int'(ret_map[5]), 1);
    end

    // R10 all ways of set 2 withdrawn; R9 uncached read of a withdrawn line
    alloc_set = 2'd2;
    #0.2 chk("R10 alloc_none when set fully withdrawn", int'(alloc_none), 1);
    read_mem(2, 0, 16'hBEEF);
    chk("R9 memory request issued", c_mreq, 1);
    chk("R9 request marked uncached", c_mbyp, 1);
    chk("R9 data from memory", c_data, 16'hBEEF);
    chk("R9 response pulse", c_valid, 1);

    // R6 uncorrectable word in a clean line
    begin
      logic [CW-1:0] cw;
      cw = enc(16'h3C3C);
      cw[6] = ~cw[6];
      cw[9] = ~cw[9];
      put_line(3, 0, cw, 1'b0);
      read_mem(3, 0, 16'h1234);
      chk("R6 refill request", c_mreq, 1);
      chk("R6 refill not uncached", c_mbyp, 0);
      chk("R6 refill set/way", c_mset * 2 + c_mway, 6);
      chk("R6 reads stalled during refill", c_wait_rdy, 0);
      chk("R6 data from refill", c_data, 16'h1234);
      chk("R6 not poisoned", c_poison, 0);
      chk("R6 line withdrawn", int'(ret_map[6]), 1);
      alloc_set = 2'd3;
      #0.2 chk("R10 set 3 fully withdrawn", int'(alloc_none), 1);
    end

    // R7 uncorrectable word in a dirty line
    begin
      logic [CW-1:0] cw;
      cw = enc(16'h9999);
      cw[12] = ~cw[12];
      cw[17] = ~cw[17];
      put_line(0, 1, cw, 1'b1);
      do_read(0, 1);
      chk("R7 response poisoned", c_poison, 1);
      chk("R7 response pulse", c_valid, 1);
      chk("R7 salvage pulse", c_slv, 1);
      chk("R7 salvage poisoned", c_slvp, 1);
      chk("R7 salvage set/way", c_slvset * 2 + c_slvway, 1);
      chk("R7 no memory request", c_mreq, 0);
      alloc_set = 2'd0;
      #0.2 chk("R10 lowest usable way of set 0", int'(alloc_way), 0);
    end

    chk("R11 final withdrawn map", int'(ret_map), 8'hF2);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule